// File: doc/BRIEF.md
# Penalty-Weighted Translation Miss Monitor

This block watches the miss traffic of a two-level address-translation buffer and turns it into one figure per fixed run of retired instructions. Each cycle it may see a strobe for a first-level miss that the second level served, a strobe for a lookup that missed both levels, and a count of 0 to 3 instructions that retired. The two miss kinds cost different numbers of cycles. A both-level miss is therefore scaled by a weight, which is the ratio of the long miss penalty to the short one. With a 5-cycle short penalty and a 25-cycle long penalty the weight is 5.

The weight is computed ahead of time and held in a register. That register can only be written while monitoring is paused, so the datapath needs no divider. While monitoring runs, the block keeps a saturating count of each miss kind and a running count of retired instructions. An epoch closes on the cycle in which the retired count reaches or passes the epoch length, which defaults to one million. On that cycle the block latches `short_misses + weight * long_misses` into a 32-bit result and raises a one-cycle done strobe. The miss counters restart from zero, and any retired instructions beyond the epoch length carry into the next epoch.

The block watches three event classes, which is within the limit of four classes observed at once. When a miss counter saturates, a sticky flag is set and stays set until reset.

Top module: `xlat_wmiss_mon`

## Requirements
- R1: After synchronous reset, `wmi_result` is 0, `epoch_done` is 0, `sat_flag` is 0 and the weight register holds 5.
- R2: A write on `wt_wr` loads `wt_data` into the weight register only while `run_en` is low. A write while `run_en` is high has no effect on later results.
- R3: While `run_en` is low, miss strobes and retire counts are ignored. Counters and the retired count hold their values.
- R4: `epoch_done` is high for exactly one cycle. It rises in the cycle after the edge at which the cumulative retired count first reaches or passes `EPOCH_LEN`.
- R5: The latched result equals the number of second-level hits plus the weight times the number of both-level misses. The count includes the events presented in the boundary cycle itself.
- R6: Retired instructions beyond `EPOCH_LEN` in the boundary cycle count toward the next epoch.
- R7: Both miss counters are cleared at the boundary, so the next result counts only events after it.
- R8: Each miss counter stops at 2^CNT_W-1 instead of wrapping. An event that arrives at that value sets `sat_flag`, which stays set until reset.
- R9: `wmi_result` holds its value between done strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Monitoring enable; low means paused and the weight is writable |
| l2_hit_ev | input | 1 | First-level miss served by second level, this cycle |
| l2_miss_ev | input | 1 | Miss in both levels, this cycle |
| retired | input | RET_W (2) | Instructions retired this cycle, 0 to 3 |
| wt_wr | input | 1 | Weight register write strobe |
| wt_data | input | W_W (8) | Weight value to write |
| wmi_result | output | RES_W (32) | Weighted miss total of the last finished epoch |
| epoch_done | output | 1 | One-cycle strobe: new result latched |
| sat_flag | output | 1 | Sticky: a miss counter has saturated |

## Verification
The assertions check several properties on every cycle. The done strobe never lasts two cycles. The weight never changes while running. Counters never move while paused and are zero right after a boundary. They never fall except at a clear. The saturation flag never drops, the result only changes alongside a done strobe, and the retired accumulator always stays below the epoch length. Other behaviours depend on the order of inputs, so only the bench scenarios can show them. These include the exact weighted value, the events of the boundary cycle being counted, the overshoot carried into the next epoch, a write made while running being ignored, and the value at which a counter saturates.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

    localparam int DEF_WEIGHT      = 5;
    localparam int MAX_CLASSES     = 4;
    localparam int MISS_CLASSES    = 2;
    localparam int WATCHED_CLASSES = MISS_CLASSES + 1;

    // index of each miss class in the counter array
    typedef enum logic [0:0] {
        CLS_L2_HIT  = 1'b0,
        CLS_L2_MISS = 1'b1
    } miss_cls_e;

    typedef struct packed {
        logic l2_hit;
        logic l2_miss;
    } miss_ev_t;

endpackage

// File: rtl/wmc_sat_cnt.sv
module wmc_sat_cnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic [W-1:0] incl,
    output logic         sat_ev
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // value including this cycle's event, pinned at TOP
    always_comb begin
        if (inc && cnt_q != TOP) incl = cnt_q + W'(1);
        else                     incl = cnt_q;
    end

    assign sat_ev = en && inc && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (en)  cnt_q <= incl;
    end

    assign cnt = cnt_q;

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt_q));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/wmc_epoch.sv
module wmc_epoch #(
    parameter int EPOCH_LEN = 1_000_000,
    parameter int RET_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [RET_W-1:0] retired,
    output logic             boundary
);
    localparam int ACC_W = $clog2(EPOCH_LEN + (1 << RET_W));
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(EPOCH_LEN);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    assign sum      = acc_q + ACC_W'(retired);
    assign boundary = en && (sum >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst)           acc_q <= '0;
        else if (boundary) acc_q <= sum - LIMIT;
        else if (en)       acc_q <= sum;
    end

    assert_acc_range_R6: assert property (@(posedge clk) disable iff (rst)
        acc_q < LIMIT);

endmodule

// File: rtl/xlat_wmiss_mon.sv
module xlat_wmiss_mon
    import wmc_pkg::*;
#(
    parameter int EPOCH_LEN = 1_000_000,
    parameter int CNT_W     = 24,
    parameter int W_W       = 8,
    parameter int RET_W     = 2,
    parameter int RES_W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             l2_hit_ev,
    input  logic             l2_miss_ev,
    input  logic [RET_W-1:0] retired,
    input  logic             wt_wr,
    input  logic [W_W-1:0]   wt_data,
    output logic [RES_W-1:0] wmi_result,
    output logic             epoch_done,
    output logic             sat_flag
);
    localparam int SUM_W = CNT_W + W_W + 1;

    miss_ev_t           ev;
    logic [CNT_W-1:0]   cnt  [MISS_CLASSES];
    logic [CNT_W-1:0]   incl [MISS_CLASSES];
    logic [MISS_CLASSES-1:0] sat_ev;
    logic [MISS_CLASSES-1:0] inc_vec;
    logic               boundary;
    logic [W_W-1:0]     weight_q;
    logic [SUM_W-1:0]   weighted;
    logic [RES_W-1:0]   result_q;
    logic               done_q;
    logic               sat_q;

    assign ev.l2_hit  = l2_hit_ev;
    assign ev.l2_miss = l2_miss_ev;
    assign inc_vec[CLS_L2_HIT]  = ev.l2_hit;
    assign inc_vec[CLS_L2_MISS] = ev.l2_miss;

    wmc_epoch #(.EPOCH_LEN(EPOCH_LEN), .RET_W(RET_W)) u_epoch (
        .clk      (clk),
        .rst      (rst),
        .en       (run_en),
        .retired  (retired),
        .boundary (boundary)
    );

    for (genvar c = 0; c < MISS_CLASSES; c++) begin : g_cnt
        wmc_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .en     (run_en),
            .clr    (boundary),
            .inc    (inc_vec[c]),
            .cnt    (cnt[c]),
            .incl   (incl[c]),
            .sat_ev (sat_ev[c])
        );
    end

    assign weighted = SUM_W'(incl[CLS_L2_HIT])
                    + SUM_W'(incl[CLS_L2_MISS]) * SUM_W'(weight_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            weight_q <= W_W'(DEF_WEIGHT);
            result_q <= '0;
            done_q   <= 1'b0;
            sat_q    <= 1'b0;
        end else begin
            if (wt_wr && !run_en) weight_q <= wt_data;
            done_q <= boundary;
            if (boundary) result_q <= RES_W'(weighted);
            if (|sat_ev)  sat_q <= 1'b1;
        end
    end

    assign wmi_result = result_q;
    assign epoch_done = done_q;
    assign sat_flag   = sat_q;

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        epoch_done |=> !epoch_done);

    assert_weight_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        run_en |=> $stable(weight_q));

    assert_counters_clear_R7: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (cnt[CLS_L2_HIT] == '0 && cnt[CLS_L2_MISS] == '0));

    assert_sat_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        sat_flag |=> sat_flag);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !epoch_done |-> $stable(wmi_result));

endmodule

// File: tb/xlat_wmiss_mon_bench.sv
module xlat_wmiss_mon_bench;

    localparam int EP   = 40;
    localparam int CW   = 8;
    localparam int WW   = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        l2_hit_ev = 1'b0;
    logic        l2_miss_ev = 1'b0;
    logic [1:0]  retired = 2'd0;
    logic        wt_wr = 1'b0;
    logic [7:0]  wt_data = 8'd0;
    logic [31:0] wmi_result;
    logic        epoch_done;
    logic        sat_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    string tag = "R1";

    // reference state
    int m_hit, m_miss, m_acc, m_w, m_res, m_done, m_ovf;

    always #4 clk = ~clk;

    xlat_wmiss_mon #(.EPOCH_LEN(EP), .CNT_W(CW), .W_W(WW)) u_xlat_wmiss_mon (
        .clk(clk), .rst(rst), .run_en(run_en),
        .l2_hit_ev(l2_hit_ev), .l2_miss_ev(l2_miss_ev), .retired(retired),
        .wt_wr(wt_wr), .wt_data(wt_data),
        .wmi_result(wmi_result), .epoch_done(epoch_done), .sat_flag(sat_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural model, advanced on every edge
    always @(posedge clk) begin
        if (rst) begin
            m_hit = 0; m_miss = 0; m_acc = 0; m_w = 5;
            m_res = 0; m_done = 0; m_ovf = 0;
        end else begin
            int h, m, s;
            m_done = 0;
            if (!run_en && wt_wr) m_w = int'(wt_data);
            if (run_en) begin
                if (l2_hit_ev  && m_hit  == CMAX) m_ovf = 1;
                if (l2_miss_ev && m_miss == CMAX) m_ovf = 1;
                h = (m_hit  + int'(l2_hit_ev)  > CMAX) ? CMAX : m_hit  + int'(l2_hit_ev);
                m = (m_miss + int'(l2_miss_ev) > CMAX) ? CMAX : m_miss + int'(l2_miss_ev);
                s = m_acc + int'(retired);
                if (s >= EP) begin
                    m_res = h + m_w * m; m_done = 1;
                    m_hit = 0; m_miss = 0; m_acc = s - EP;
                end else begin
                    m_hit = h; m_miss = m; m_acc = s;
                end
            end
        end
    end

    always @(posedge clk) begin
        #2;
        chk(tag, "result", int'(wmi_result), m_res);
        chk(tag, "done", int'(epoch_done), m_done);
        chk(tag, "sat", int'(sat_flag), m_ovf);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 200000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(input logic r, input logic h, input logic m,
                        input int rt, input logic w, input int wd);
        @(negedge clk);
        run_en = r; l2_hit_ev = h; l2_miss_ev = m;
        retired = 2'(rt); wt_wr = w; wt_data = 8'(wd);
    endtask

    task automatic after_edge();
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (3) step(0, 0, 0, 0, 0, 0);
        @(negedge clk); rst = 1'b0;
        after_edge();
        chk("R1", "reset result", int'(wmi_result), 0);
        chk("R1", "reset done", int'(epoch_done), 0);
        chk("R1", "reset sat", int'(sat_flag), 0);

        // R1 default weight 5 and R5: 3 hits, 2 misses, boundary at cycle 14 (sum 42)
        tag = "R5";
        for (int i = 0; i < 13; i++) step(1, i < 3, i < 2, 3, 0, 0);
        step(1, 0, 0, 3, 0, 0);
        after_edge();
        chk("R1", "default weight result", int'(wmi_result), 13);
        chk("R4", "done at boundary", int'(epoch_done), 1);

        // R2: idle write of 3, running write of 9 ignored; carry 2 + 19*2 = 40
        tag = "R2";
        step(0, 0, 0, 0, 1, 3);
        for (int i = 0; i < 18; i++) step(1, 1, 1, 2, i == 5, 9);
        step(1, 1, 1, 2, 0, 0);
        after_edge();
        chk("R2", "result with weight 3", int'(wmi_result), 76);

        // R3: paused traffic ignored; then boundary-cycle events counted (R5)
        tag = "R3";
        for (int i = 0; i < 10; i++) step(0, 1, 1, 3, 0, 0);
        for (int i = 0; i < 39; i++) step(1, 0, 0, 1, 0, 0);
        after_edge();
        chk("R4", "no done before boundary", int'(epoch_done), 0);
        step(1, 1, 1, 3, 0, 0);
        after_edge();
        chk("R5", "boundary events counted", int'(wmi_result), 4);
        chk("R4", "done asserted", int'(epoch_done), 1);
        step(0, 0, 0, 0, 0, 0);
        after_edge();
        chk("R4", "done one cycle", int'(epoch_done), 0);

        // R6: carry of 2 means 38 more retire end the epoch
        tag = "R6";
        for (int i = 0; i < 37; i++) step(1, 0, i == 0, 1, 0, 0);
        after_edge();
        chk("R6", "not yet ended", int'(epoch_done), 0);
        step(1, 0, 0, 1, 0, 0);
        after_edge();
        chk("R6", "ended with carry", int'(epoch_done), 1);
        chk("R6", "result", int'(wmi_result), 3);

        // R7: fresh epoch counts only its own events
        tag = "R7";
        for (int i = 0; i < 20; i++) step(1, i == 19, 0, 2, 0, 0);
        after_edge();
        chk("R7", "cleared counters", int'(wmi_result), 1);

        // R8: saturate both counters
        tag = "R8";
        for (int i = 0; i < 300; i++) step(1, 1, 1, 0, 0, 0);
        after_edge();
        chk("R8", "sticky set", int'(sat_flag), 1);
        for (int i = 0; i < 20; i++) step(1, 0, 0, 2, 0, 0);
        after_edge();
        chk("R8", "saturated result", int'(wmi_result), CMAX + 3 * CMAX);

        // R9: result holds while idle and while running mid-epoch
        tag = "R9";
        for (int i = 0; i < 5; i++) step(0, 1, 1, 3, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 0, 0);
        after_edge();
        chk("R9", "result held", int'(wmi_result), 1020);
        chk("R8", "sticky kept", int'(sat_flag), 1);

        step(0, 0, 0, 0, 0, 0);
        after_edge();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule